// File: doc/BRIEF.md
# I2C Message List Sequencer

This block runs a whole I2C transaction on its own, one message after another, by reacting to the status codes reported by a byte-level bus master. It never drives the bus lines itself. Each message descriptor gives a 10-bit target address, a 10-bit-mode flag, a direction, a byte count and a flag marking it as the final message of the transaction. Bytes to write arrive on a valid/ready stream. Received bytes leave on another valid/ready stream.

For every status event it accepts, the sequencer issues at most one command to the byte master. The command can be a START (or repeated START), a STOP, the transmission of one byte, or the reception of one byte with a chosen acknowledge level. A write message that is not the last one chains into the next message through a repeated START. A read message always closes the transaction, because its final byte is NACKed and then followed by STOP.

An abort input lets the transaction end cleanly at the next byte boundary. Every transaction ends with a one-cycle `done` pulse that carries a 2-bit result code.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: With 7-bit addressing, the first address byte sent is `{addr[6:0], rd}`, where rd is 1 for a read.
- R2: With 10-bit addressing, the first address byte is `8'hF0 | {addr[9:8],1'b0} | rd`. The second address byte is `addr[7:0]`, sent in reply to status 8'h18 (write) or 8'h40 (read).
- R3: Accepting a message while idle issues a START. Status 8'h08 or 8'h10 sends the first address byte. A write message that ends without being last issues a START (repeated) and then accepts the next descriptor.
- R4: On status 8'h18 (7-bit), 8'hD0 or 8'h28 with bytes remaining, exactly one byte is taken from the write stream and sent. With none remaining, the sequencer issues STOP with done if the message is last, and otherwise continues as in R3.
- R5: On a read, receive commands carry ack=1 except when exactly one byte remains or an abort is pending, in which case ack=0. Status 8'h50 delivers its byte and requests the next one. Status 8'h58 delivers the final byte and then issues STOP with done, err=0.
- R6: A read of length zero issues STOP with done right after the read-address ACK (8'h40 or 8'hE0), and no byte is delivered.
- R7: Status 8'h20, 8'h30 or 8'h48 leads to STOP with done and err=1 (no device).
- R8: Any other status code leads to STOP, a one-cycle `ctl_reset` pulse and done with err=2 (controller error).
- R9: A status that arrives while idle produces only a STOP: no done, no `ctl_reset`.
- R10: `abort_req` sets a pending flag while a transaction runs. A write then stops once at least one data byte has been sent, and a read NACKs the next byte. Either way the sequencer finishes with err=3. `abort_req` while idle has no effect.
- R11: `done` lasts one cycle and coincides with a STOP command. A presented read byte stays valid and stable until it is accepted.
- R12: Every command is a one-cycle pulse with exactly one of start, stop, send or receive set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message descriptor offered |
| msg_ready | output | 1 | Descriptor accepted this cycle when valid |
| msg_addr | input | 10 | Target address |
| msg_ten | input | 1 | 10-bit addressing |
| msg_rd | input | 1 | 1 = read, 0 = write |
| msg_len | input | LEN_W | Byte count |
| msg_last | input | 1 | Final message of the transaction |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte accepted |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Received byte offered |
| rd_ready | input | 1 | Received byte accepted |
| rd_data | output | 8 | Received byte |
| abort_req | input | 1 | Request a graceful abort |
| st_valid | input | 1 | Status event from the byte master |
| st_ready | output | 1 | Status event consumed |
| st_code | input | 8 | Status code |
| st_rxbyte | input | 8 | Byte received with the status |
| cmd_valid | output | 1 | Command pulse |
| cmd_start | output | 1 | Issue START / repeated START |
| cmd_stop | output | 1 | Issue STOP |
| cmd_send | output | 1 | Transmit cmd_byte |
| cmd_recv | output | 1 | Receive one byte |
| cmd_ack | output | 1 | ACK level for a receive |
| cmd_byte | output | 8 | Byte to transmit |
| ctl_reset | output | 1 | Reset pulse to the byte master |
| done | output | 1 | Transaction finished |
| err | output | 2 | 0 ok, 1 no device, 2 controller error, 3 aborted |

## Verification
The hardest case to reach is an abort that lands in a particular phase: after the address but before any data byte of a write, between two data bytes, or in the middle of a read. The bench plays the byte master one status event at a time and pulses `abort_req` between two chosen events, so the point of the abort is exact. It then checks whether the sequencer asks for another write byte or NACKs the next read. A second situation that is hard to provoke is the read stream applying back-pressure while the final 8'h58 byte is pending. The bench holds `rd_ready` low for several cycles and confirms that the STOP waits.

// File: rtl/i2c_msg_sequencer.sv
module i2c_msg_sequencer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [9:0]       msg_addr,
  input  logic             msg_ten,
  input  logic             msg_rd,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             msg_last,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  input  logic             abort_req,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic [7:0]       st_code,
  input  logic [7:0]       st_rxbyte,
  output logic             cmd_valid,
  output logic             cmd_start,
  output logic             cmd_stop,
  output logic             cmd_send,
  output logic             cmd_recv,
  output logic             cmd_ack,
  output logic [7:0]       cmd_byte,
  output logic             ctl_reset,
  output logic             done,
  output logic [1:0]       err
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_NEED_WR, S_PUSH, S_NEXT} state_t;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RESTART = 8'h10;
  localparam logic [7:0] ST_WA_ACK  = 8'h18;
  localparam logic [7:0] ST_WA_NAK  = 8'h20;
  localparam logic [7:0] ST_WD_ACK  = 8'h28;
  localparam logic [7:0] ST_WD_NAK  = 8'h30;
  localparam logic [7:0] ST_RA_ACK  = 8'h40;
  localparam logic [7:0] ST_RA_NAK  = 8'h48;
  localparam logic [7:0] ST_RD_ACK  = 8'h50;
  localparam logic [7:0] ST_RD_NAK  = 8'h58;
  localparam logic [7:0] ST_WA2_ACK = 8'hD0;
  localparam logic [7:0] ST_RA2_ACK = 8'hE0;

  localparam logic [1:0] E_NONE  = 2'd0;
  localparam logic [1:0] E_NODEV = 2'd1;
  localparam logic [1:0] E_IO    = 2'd2;
  localparam logic [1:0] E_ABORT = 2'd3;

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  state_t           state, n_state;
  logic [9:0]       m_addr;
  logic             m_ten, m_rd, m_last;
  logic [LEN_W-1:0] left, n_left;
  logic             sent, n_sent;
  logic             abort_p, n_abort;
  logic             fin, n_fin;
  logic [7:0]       rxbuf, n_rx;
  logic             ld;

  logic             c_start, c_stop, c_send, c_recv, c_ack, c_reset, c_done;
  logic [7:0]       c_byte;
  logic [1:0]       c_err;

  logic [7:0]       addr1, addr2;
  logic             wr_end;
  logic [1:0]       ok_code;

  assign addr1 = m_ten ? {5'b11110, m_addr[9:8], m_rd} : {m_addr[6:0], m_rd};
  assign addr2 = m_addr[7:0];
  assign wr_end = (left == '0) || (abort_p && sent);
  assign ok_code = abort_p ? E_ABORT : E_NONE;

  assign msg_ready = (state == S_IDLE && !st_valid) || state == S_NEXT;
  assign st_ready  = state == S_IDLE || state == S_WAIT;
  assign wr_ready  = state == S_NEED_WR;
  assign rd_valid  = state == S_PUSH;
  assign rd_data   = rxbuf;

  always_comb begin
    n_state = state;
    n_left  = left;
    n_sent  = sent;
    n_fin   = fin;
    n_rx    = rxbuf;
    n_abort = abort_p | (abort_req && state != S_IDLE);
    ld      = 1'b0;
    c_start = 1'b0;
    c_stop  = 1'b0;
    c_send  = 1'b0;
    c_recv  = 1'b0;
    c_ack   = 1'b0;
    c_byte  = 8'h00;
    c_reset = 1'b0;
    c_done  = 1'b0;
    c_err   = E_NONE;
    case (state)
      S_IDLE: begin
        if (st_valid) begin
          c_stop = 1'b1;
        end else if (msg_valid) begin
          ld      = 1'b1;
          n_sent  = 1'b0;
          n_abort = 1'b0;
          c_start = 1'b1;
          n_state = S_WAIT;
        end
      end
      S_WAIT: begin
        if (st_valid) begin
          case (st_code)
            ST_START, ST_RESTART: begin
              c_send = 1'b1;
              c_byte = addr1;
            end
            ST_WA_ACK, ST_WA2_ACK, ST_WD_ACK: begin
              if (st_code == ST_WA_ACK && m_ten) begin
                c_send = 1'b1;
                c_byte = addr2;
              end else if (!wr_end) begin
                n_state = S_NEED_WR;
              end else if (m_last || abort_p) begin
                c_stop  = 1'b1;
                c_done  = 1'b1;
                c_err   = ok_code;
                n_state = S_IDLE;
              end else begin
                c_start = 1'b1;
                n_state = S_NEXT;
              end
            end
            ST_RA_ACK, ST_RA2_ACK: begin
              if (st_code == ST_RA_ACK && m_ten) begin
                c_send = 1'b1;
                c_byte = addr2;
              end else if (left == '0) begin
                c_stop  = 1'b1;
                c_done  = 1'b1;
                c_err   = ok_code;
                n_state = S_IDLE;
              end else begin
                c_recv = 1'b1;
                c_ack  = !(left == ONE || abort_p);
              end
            end
            ST_RD_ACK: begin
              n_rx    = st_rxbyte;
              n_left  = left - ONE;
              n_fin   = 1'b0;
              n_state = S_PUSH;
            end
            ST_RD_NAK: begin
              n_rx    = st_rxbyte;
              n_fin   = 1'b1;
              n_state = S_PUSH;
            end
            ST_WA_NAK, ST_WD_NAK, ST_RA_NAK: begin
              c_stop  = 1'b1;
              c_done  = 1'b1;
              c_err   = E_NODEV;
              n_state = S_IDLE;
            end
            default: begin
              c_stop  = 1'b1;
              c_reset = 1'b1;
              c_done  = 1'b1;
              c_err   = E_IO;
              n_state = S_IDLE;
            end
          endcase
        end
      end
      S_NEED_WR: begin
        if (wr_valid) begin
          c_send  = 1'b1;
          c_byte  = wr_data;
          n_left  = left - ONE;
          n_sent  = 1'b1;
          n_state = S_WAIT;
        end
      end
      S_PUSH: begin
        if (rd_ready) begin
          if (fin) begin
            c_stop  = 1'b1;
            c_done  = 1'b1;
            c_err   = ok_code;
            n_state = S_IDLE;
          end else begin
            c_recv  = 1'b1;
            c_ack   = !(left == ONE || abort_p);
            n_state = S_WAIT;
          end
        end
      end
      S_NEXT: begin
        if (msg_valid) begin
          ld      = 1'b1;
          n_sent  = 1'b0;
          n_state = S_WAIT;
        end
      end
      default: n_state = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      m_addr    <= '0;
      m_ten     <= 1'b0;
      m_rd      <= 1'b0;
      m_last    <= 1'b0;
      left      <= '0;
      sent      <= 1'b0;
      abort_p   <= 1'b0;
      fin       <= 1'b0;
      rxbuf     <= '0;
      cmd_valid <= 1'b0;
      cmd_start <= 1'b0;
      cmd_stop  <= 1'b0;
      cmd_send  <= 1'b0;
      cmd_recv  <= 1'b0;
      cmd_ack   <= 1'b0;
      cmd_byte  <= '0;
      ctl_reset <= 1'b0;
      done      <= 1'b0;
      err       <= E_NONE;
    end else begin
      state   <= n_state;
      sent    <= n_sent;
      abort_p <= n_abort;
      fin     <= n_fin;
      rxbuf   <= n_rx;
      if (ld) begin
        m_addr <= msg_addr;
        m_ten  <= msg_ten;
        m_rd   <= msg_rd;
        m_last <= msg_last;
        left   <= msg_len;
      end else begin
        left <= n_left;
      end
      cmd_valid <= c_start | c_stop | c_send | c_recv;
      cmd_start <= c_start;
      cmd_stop  <= c_stop;
      cmd_send  <= c_send;
      cmd_recv  <= c_recv;
      cmd_ack   <= c_ack;
      cmd_byte  <= c_byte;
      ctl_reset <= c_reset;
      done      <= c_done;
      err       <= c_err;
    end
  end

  // R12
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $onehot({cmd_start, cmd_stop, cmd_send, cmd_recv}));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_stop);

  // R8
  reset_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |-> (done && err == E_IO));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R4
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (cmd_send && cmd_byte == $past(wr_data)));

  // R9
  idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && st_valid) |=> (cmd_stop && !done && !ctl_reset));

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && msg_valid && msg_ready) |=> cmd_start);

endmodule

// File: tb/i2c_msg_sequencer_test.sv
`timescale 1ns/1ps
module i2c_msg_sequencer_test;
  logic clk = 0, rst_n = 0;
  logic msg_valid = 0, msg_ready;
  logic [9:0] msg_addr = 0;
  logic msg_ten = 0, msg_rd = 0, msg_last = 0;
  logic [7:0] msg_len = 0;
  logic wr_valid = 0, wr_ready;
  logic [7:0] wr_data = 0;
  logic rd_valid, rd_ready = 1;
  logic [7:0] rd_data;
  logic abort_req = 0;
  logic st_valid = 0, st_ready;
  logic [7:0] st_code = 0, st_rxbyte = 0;
  logic cmd_valid, cmd_start, cmd_stop, cmd_send, cmd_recv, cmd_ack, ctl_reset, done;
  logic [7:0] cmd_byte;
  logic [1:0] err;

  int tests = 0, fails = 0;
  int log_k [64];
  int log_b [64];
  int n_log = 0, rp = 0, done_n = 0, rst_cnt = 0, n_rd = 0;
  logic [1:0] done_err;
  logic [7:0] rd_log [16];
  logic rd_seen = 0;

  always #2.5 clk = ~clk;

  i2c_msg_sequencer #(.LEN_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_ten(msg_ten), .msg_rd(msg_rd), .msg_len(msg_len),
    .msg_last(msg_last), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .abort_req(abort_req),
    .st_valid(st_valid), .st_ready(st_ready), .st_code(st_code), .st_rxbyte(st_rxbyte),
    .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_send(cmd_send),
    .cmd_recv(cmd_recv), .cmd_ack(cmd_ack), .cmd_byte(cmd_byte), .ctl_reset(ctl_reset),
    .done(done), .err(err));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (cmd_valid && n_log < 64) begin
      log_k[n_log] = cmd_start ? 1 : cmd_stop ? 2 : cmd_send ? 3 : 4;
      log_b[n_log] = cmd_send ? int'(cmd_byte) : int'(cmd_ack);
      n_log++;
      if ($countones({cmd_start, cmd_stop, cmd_send, cmd_recv}) != 1)
        chk(0, "R12 one-hot command", $countones({cmd_start, cmd_stop, cmd_send, cmd_recv}), 1);
    end
    if (done) begin done_n++; done_err = err; end
    if (ctl_reset) rst_cnt++;
    if (rd_valid && !rd_seen && n_rd < 16) begin rd_log[n_rd] = rd_data; n_rd++; end
    rd_seen = rd_valid;
  end

  task automatic clr();
    n_log = 0; rp = 0; done_n = 0; rst_cnt = 0; n_rd = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic put_msg(input logic [9:0] a, input logic ten, input logic rd,
                         input logic [7:0] len, input logic last);
    @(negedge clk);
    msg_addr = a; msg_ten = ten; msg_rd = rd; msg_len = len; msg_last = last; msg_valid = 1;
    while (!msg_ready) @(negedge clk);
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic status(input logic [7:0] code, input logic [7:0] rx);
    @(negedge clk);
    st_code = code; st_rxbyte = rx; st_valid = 1;
    while (!st_ready) @(negedge clk);
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic feed(input logic [7:0] b);
    @(negedge clk);
    wr_data = b; wr_valid = 1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic pulse_abort();
    @(negedge clk);
    abort_req = 1;
    @(negedge clk);
    abort_req = 0;
  endtask

  // kind: 1 start, 2 stop, 3 send (b = byte), 4 receive (b = ack)
  task automatic exp_cmd(input int k, input int b, input string tag);
    if (rp >= n_log) begin
      chk(0, tag, -1, k);
    end else begin
      chk(log_k[rp] == k, tag, log_k[rp], k);
      if (k >= 3) chk(log_b[rp] == b, tag, log_b[rp], b);
    end
    rp++;
  endtask

  task automatic exp_done(input logic [1:0] e, input string tag);
    chk(done_n == 1, {tag, " done count"}, done_n, 1);
    chk(done_err == e, {tag, " err"}, done_err, e);
    chk(rp == n_log, {tag, " command count"}, n_log, rp);
  endtask

  task automatic t_reset();
    chk(msg_ready && st_ready && !cmd_valid && !done && !rd_valid && !wr_ready && !ctl_reset,
        "reset state", {msg_ready, st_ready, cmd_valid, done, rd_valid, wr_ready}, 6'b110000);
  endtask

  task automatic t_write7();
    clr();
    put_msg(10'h050, 0, 0, 2, 1);
    status(8'h08, 0); status(8'h18, 0); feed(8'h11);
    status(8'h28, 0); feed(8'h22); status(8'h28, 0); settle();
    exp_cmd(1, 0, "R3 start");
    exp_cmd(3, 8'hA0, "R1 seven-bit address");
    exp_cmd(3, 8'h11, "R4 data 1");
    exp_cmd(3, 8'h22, "R4 data 2");
    exp_cmd(2, 0, "R4 stop on last");
    exp_done(0, "R11 write done");
  endtask

  task automatic t_chain();
    clr();
    put_msg(10'h2A5, 1, 0, 1, 0);
    status(8'h08, 0); status(8'h18, 0); status(8'hD0, 0); feed(8'h5C);
    status(8'h28, 0);
    put_msg(10'h01B, 0, 1, 2, 1);
    status(8'h10, 0); status(8'h40, 0); status(8'h50, 8'h81); status(8'h58, 8'h82); settle();
    exp_cmd(1, 0, "R3 start");
    exp_cmd(3, 8'hF4, "R2 ten-bit first byte");
    exp_cmd(3, 8'hA5, "R2 ten-bit second byte");
    exp_cmd(3, 8'h5C, "R4 data");
    exp_cmd(1, 0, "R3 repeated start");
    exp_cmd(3, 8'h37, "R3 address after restart");
    exp_cmd(4, 1, "R5 ack while two left");
    exp_cmd(4, 0, "R5 nack on final byte");
    exp_cmd(2, 0, "R5 stop after 0x58");
    exp_done(0, "R5 chain done");
    chk(n_rd == 2, "R5 read count", n_rd, 2);
    chk(rd_log[0] == 8'h81 && rd_log[1] == 8'h82, "R5 read bytes", {rd_log[0], rd_log[1]}, 16'h8182);
  endtask

  task automatic t_read10();
    clr();
    put_msg(10'h3C7, 1, 1, 1, 1);
    status(8'h08, 0); status(8'h40, 0); status(8'hE0, 0); status(8'h58, 8'h99); settle();
    exp_cmd(1, 0, "R3 start");
    exp_cmd(3, 8'hF7, "R2 ten-bit read first byte");
    exp_cmd(3, 8'hC7, "R2 ten-bit read second byte");
    exp_cmd(4, 0, "R5 single byte nack");
    exp_cmd(2, 0, "R5 stop");
    exp_done(0, "R5 ten-bit read");
    chk(n_rd == 1 && rd_log[0] == 8'h99, "R5 ten-bit read byte", rd_log[0], 8'h99);
  endtask

  task automatic t_zero_read();
    clr();
    put_msg(10'h010, 0, 1, 0, 1);
    status(8'h08, 0); status(8'h40, 0); settle();
    exp_cmd(1, 0, "R6 start");
    exp_cmd(3, 8'h21, "R6 address");
    exp_cmd(2, 0, "R6 stop after address ack");
    exp_done(0, "R6 zero read");
    chk(n_rd == 0, "R6 no byte delivered", n_rd, 0);
  endtask

  task automatic t_nack();
    clr();
    put_msg(10'h022, 0, 0, 1, 1);
    status(8'h08, 0); status(8'h20, 0); settle();
    exp_cmd(1, 0, "R7 start"); exp_cmd(3, 8'h44, "R7 address"); exp_cmd(2, 0, "R7 stop");
    exp_done(1, "R7 write address nack");
    clr();
    put_msg(10'h022, 0, 1, 1, 1);
    status(8'h08, 0); status(8'h48, 0); settle();
    exp_cmd(1, 0, "R7 start"); exp_cmd(3, 8'h45, "R7 address"); exp_cmd(2, 0, "R7 stop");
    exp_done(1, "R7 read address nack");
    clr();
    put_msg(10'h022, 0, 0, 2, 1);
    status(8'h08, 0); status(8'h18, 0); feed(8'h01); status(8'h30, 0); settle();
    exp_cmd(1, 0, "R7 start"); exp_cmd(3, 8'h44, "R7 address");
    exp_cmd(3, 8'h01, "R7 data"); exp_cmd(2, 0, "R7 stop");
    exp_done(1, "R7 data nack");
  endtask

  task automatic t_unexpected();
    clr();
    put_msg(10'h033, 0, 0, 1, 1);
    status(8'h08, 0); status(8'h38, 0); settle();
    exp_cmd(1, 0, "R8 start"); exp_cmd(3, 8'h66, "R8 address"); exp_cmd(2, 0, "R8 stop");
    exp_done(2, "R8 controller error");
    chk(rst_cnt == 1, "R8 reset pulse", rst_cnt, 1);
  endtask

  task automatic t_idle_status();
    clr();
    status(8'hF8, 0); settle();
    exp_cmd(2, 0, "R9 stop only");
    chk(done_n == 0 && rst_cnt == 0, "R9 no done no reset", {done_n[3:0], rst_cnt[3:0]}, 0);
    chk(n_log == 1, "R9 single command", n_log, 1);
  endtask

  task automatic t_abort_write();
    clr();
    put_msg(10'h040, 0, 0, 3, 1);
    status(8'h08, 0); status(8'h18, 0); feed(8'hB0);
    pulse_abort();
    status(8'h28, 0); settle();
    exp_cmd(1, 0, "R10 start"); exp_cmd(3, 8'h80, "R10 address");
    exp_cmd(3, 8'hB0, "R10 data"); exp_cmd(2, 0, "R10 stop after abort");
    exp_done(3, "R10 write abort");
    clr();
    put_msg(10'h041, 0, 0, 2, 1);
    pulse_abort();
    status(8'h08, 0); status(8'h18, 0);
    chk(wr_ready == 1, "R10 first byte still sent", wr_ready, 1);
    feed(8'hB1); status(8'h28, 0); settle();
    exp_cmd(1, 0, "R10 start"); exp_cmd(3, 8'h82, "R10 address");
    exp_cmd(3, 8'hB1, "R10 one byte before abort"); exp_cmd(2, 0, "R10 stop");
    exp_done(3, "R10 early write abort");
  endtask

  task automatic t_abort_read();
    clr();
    put_msg(10'h048, 0, 1, 4, 1);
    status(8'h08, 0); status(8'h40, 0);
    pulse_abort();
    status(8'h50, 8'h10); status(8'h58, 8'h20); settle();
    exp_cmd(1, 0, "R10 start"); exp_cmd(3, 8'h91, "R10 address");
    exp_cmd(4, 1, "R5 ack with four left");
    exp_cmd(4, 0, "R10 nack after abort");
    exp_cmd(2, 0, "R10 stop");
    exp_done(3, "R10 read abort");
    chk(n_rd == 2, "R10 bytes delivered", n_rd, 2);
  endtask

  task automatic t_abort_idle();
    clr();
    pulse_abort();
    put_msg(10'h005, 0, 0, 1, 1);
    status(8'h08, 0); status(8'h18, 0); feed(8'h77); status(8'h28, 0); settle();
    exp_cmd(1, 0, "R10 start"); exp_cmd(3, 8'h0A, "R10 address");
    exp_cmd(3, 8'h77, "R10 data"); exp_cmd(2, 0, "R10 stop");
    exp_done(0, "R10 idle abort ignored");
  endtask

  task automatic t_rd_hold();
    clr();
    put_msg(10'h006, 0, 1, 1, 1);
    status(8'h08, 0); status(8'h40, 0);
    rd_ready = 0;
    status(8'h58, 8'h3D);
    repeat (4) @(negedge clk);
    chk(rd_valid == 1 && rd_data == 8'h3D, "R11 read byte held", rd_data, 8'h3D);
    chk(done_n == 0, "R11 stop waits for read", done_n, 0);
    rd_ready = 1;
    settle();
    exp_cmd(1, 0, "R11 start"); exp_cmd(3, 8'h0D, "R11 address");
    exp_cmd(4, 0, "R5 nack single"); exp_cmd(2, 0, "R11 stop");
    exp_done(0, "R11 held read");
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write7();
    t_chain();
    t_read10();
    t_zero_read();
    t_nack();
    t_unexpected();
    t_idle_status();
    t_abort_write();
    t_abort_read();
    t_abort_idle();
    t_rd_hold();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule